// File: doc/BRIEF.md
# Serial Transmitter with Line-Break Sequencer

This block serialises characters onto an asynchronous serial line. A character written to a one-deep holding stage moves into a frame shifter at the next free bit slot. The frame goes out as a low start bit, the data bits least significant first, an optional ninth bit that marks the frame as an address or as data, and a high stop bit. Each bit occupies one interval of the `baud_tick` strobe. Characters written while the shifter is busy follow the current frame with no idle gap.

Control is by single-cycle command strobes. A strobe held low does nothing. One strobe each switches the transmitter on, switches it off, resets it, begins a line break, ends a line break, and flags the next written character as an address. A requested break waits until every queued character has left the line. It then holds the line low in whole frame lengths. When it is released, it ends at the next frame boundary, and the line then stays high for a guard interval of at least twelve bit times. Two status outputs show whether the holding stage can take a character and whether the whole transmit path is quiet.

Top module: `uart_brk_tx`

## Requirements
- R1: While nothing is being sent, `tx_line` is 1. A frame starts at the first `baud_tick` edge after the character reaches the holding stage. Each bit lasts one tick interval, in this order: a 0 start bit, `wr_data` bit 0 first, then the ninth bit when `multidrop_en`=1, then a 1 stop bit. A character already waiting starts on the tick right after the previous stop bit.
- R2: `tx_ready` is 1 exactly when the transmitter is on, the holding stage is empty and no break activity exists. A write presented while `tx_ready` is 0 is discarded and never appears on the line.
- R3: `tx_empty` is 0 from the cycle after a write is accepted until the stop bit of the last queued character has lasted its full tick interval. It is also 0 during any break activity.
- R4: A break request forces `tx_ready` and `tx_empty` to 0 on the next cycle. Any character in the holding stage or the shifter is sent in full before the line goes low.
- R5: A break request made while a break is waiting, on the line, or in its guard interval is ignored.
- R6: During a break, `tx_line` is 0 for a whole number of frame lengths: 10 bit times per frame with `multidrop_en`=0, or 11 with `multidrop_en`=1. A release takes effect at the end of the frame in which it arrives.
- R7: After a break ends, `tx_line` is 1 for max(`guard_len`, 12) tick intervals. During that interval `tx_ready` is 0. Then the transmitter returns to idle.
- R8: A break release made when no break is on the line, whether idle or still waiting for data to drain, has no effect.
- R9: With `multidrop_en`=1, a character accepted on the cycle of `cmd_addr_next` or after it carries a ninth bit of 1 (address). The flag is used up by that character, and later characters carry 0 (data).
- R10: `cmd_tx_on` switches the transmitter on only when `cmd_tx_off` is low in the same cycle. The off strobe wins.
- R11: `cmd_tx_rst` aborts any frame or break at once. It empties the holding stage, switches the transmitter off and drives `tx_line` to 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle strobe, one per bit time |
| wr_valid | input | 1 | Write strobe for the holding stage |
| wr_data | input | DATA_W | Character to send |
| cmd_tx_on | input | 1 | Switch transmitter on |
| cmd_tx_off | input | 1 | Switch transmitter off |
| cmd_tx_rst | input | 1 | Reset transmit path to idle |
| cmd_brk_start | input | 1 | Request a line break |
| cmd_brk_stop | input | 1 | Release a line break |
| cmd_addr_next | input | 1 | Mark next character as address |
| multidrop_en | input | 1 | Add the address/data ninth bit |
| guard_len | input | GUARD_W | Requested post-break idle, in bit times |
| tx_line | output | 1 | Serial output |
| tx_ready | output | 1 | Holding stage can take a character |
| tx_empty | output | 1 | Nothing queued, sending or breaking |

## Verification
The assertions run on every cycle and check the following. A break reaches the line only with both the holding stage and the shifter empty. A guard interval never ends in fewer than twelve ticks. A break leaves the low state only at a frame boundary. A held character is never overwritten. Reset and the off strobe take effect on the next cycle. Only the bench scenarios can show the bit order of whole frames, back-to-back frames, the exact low and high counts for both frame lengths and guard settings, and the way the address flag is used up. The same holds for ignored break requests and releases, because their effect shows up only as line timing over many ticks.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;

   typedef enum logic [1:0] {
      BRK_OFF   = 2'd0,
      BRK_PEND  = 2'd1,
      BRK_LOW   = 2'd2,
      BRK_GUARD = 2'd3
   } brk_st_t;

   function automatic int frame_bits(input int data_w, input int with_addr);
      return data_w + 2 + ((with_addr != 0) ? 1 : 0);
   endfunction

endpackage

// File: rtl/uart_brk_hold.sv
module uart_brk_hold #(
   parameter int DATA_W      = 8,
   parameter int ADDR_BIT_EN = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              addr_cmd,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] hold_data,
   output logic              hold_addr
);

   logic              full_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else if (clr) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else if (wr_en) begin
         full_q <= 1'b1;
         data_q <= wr_data;
      end else if (take) begin
         full_q <= 1'b0;
      end
   end

   generate
      if (ADDR_BIT_EN != 0) begin : g_addr
         logic pend_q;
         logic addr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_q <= 1'b0;
               addr_q <= 1'b0;
            end else if (clr) begin
               pend_q <= 1'b0;
               addr_q <= 1'b0;
            end else if (wr_en) begin
               addr_q <= pend_q | addr_cmd;
               pend_q <= 1'b0;
            end else if (addr_cmd) begin
               pend_q <= 1'b1;
            end
         end
         assign hold_addr = addr_q;
      end else begin : g_noaddr
         assign hold_addr = 1'b0;
      end
   endgenerate

   assign full      = full_q;
   assign hold_data = data_q;

   AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !full_q) else $error("write into a full holding stage"); // R2
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && $past(full_q) && !$past(take) && !$past(clr)) |-> $stable(data_q))
      else $error("held character changed"); // R2

endmodule

// File: rtl/uart_brk_shift.sv
module uart_brk_shift #(
   parameter int DATA_W      = 8,
   parameter int ADDR_BIT_EN = 1,
   parameter int FRAME_W     = 11,
   parameter int CNT_W       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              tick,
   input  logic              load_ok,
   input  logic [DATA_W-1:0] hold_data,
   input  logic              hold_addr,
   input  logic              md,
   output logic              line,
   output logic              busy,
   output logic              slot,
   output logic              take
);

   logic [FRAME_W-1:0] frame_q;
   logic [FRAME_W-1:0] frm_new;
   logic [CNT_W-1:0]   idx_q;
   logic [CNT_W-1:0]   last_q;
   logic [CNT_W-1:0]   last_new;
   logic               busy_q;
   logic               line_q;
   logic               more;

   generate
      if (ADDR_BIT_EN != 0) begin : g_nine
         always_comb begin
            if (md) begin
               frm_new  = {1'b1, hold_addr, hold_data, 1'b0};
               last_new = CNT_W'(FRAME_W - 1);
            end else begin
               frm_new  = {1'b1, 1'b1, hold_data, 1'b0};
               last_new = CNT_W'(FRAME_W - 2);
            end
         end
      end else begin : g_eight
         assign frm_new  = {1'b1, hold_data, 1'b0};
         assign last_new = CNT_W'(FRAME_W - 1);
      end
   endgenerate

   assign more = busy_q && (idx_q != last_q);
   assign slot = !more;
   assign take = tick && slot && load_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '1;
         idx_q   <= '0;
         last_q  <= '0;
         busy_q  <= 1'b0;
         line_q  <= 1'b1;
      end else if (clr) begin
         frame_q <= '1;
         idx_q   <= '0;
         last_q  <= '0;
         busy_q  <= 1'b0;
         line_q  <= 1'b1;
      end else if (tick) begin
         if (more) begin
            idx_q   <= idx_q + CNT_W'(1);
            line_q  <= frame_q[1];
            frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
         end else if (load_ok) begin
            busy_q  <= 1'b1;
            idx_q   <= '0;
            frame_q <= frm_new;
            last_q  <= last_new;
            line_q  <= 1'b0;
         end else begin
            busy_q  <= 1'b0;
            line_q  <= 1'b1;
         end
      end
   end

   assign line = line_q;
   assign busy = busy_q;

   AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !clr) |=> !line_q) else $error("frame did not open with a low bit"); // R1
   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (idx_q <= last_q)) else $error("bit index beyond frame"); // R1
   AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && idx_q == last_q) |-> line_q) else $error("last bit not high"); // R1

endmodule

// File: rtl/uart_brk_seq.sv
module uart_brk_seq
   import uart_brk_pkg::*;
#(
   parameter int GUARD_W   = 8,
   parameter int MIN_GUARD = 12,
   parameter int CNT_W     = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               tick,
   input  logic               start_cmd,
   input  logic               stop_cmd,
   input  logic               drained,
   input  logic [CNT_W-1:0]   flen_last,
   input  logic [GUARD_W-1:0] guard_len,
   output brk_st_t            st,
   output logic               ovr,
   output logic               lvl
);

   localparam logic [GUARD_W-1:0] GMIN = GUARD_W'(MIN_GUARD);

   brk_st_t            st_q;
   logic [CNT_W-1:0]   pos_q;
   logic [GUARD_W-1:0] gcnt_q;
   logic [GUARD_W-1:0] glim_q;
   logic [GUARD_W-1:0] glim_new;
   logic               stop_q;

   assign glim_new = (guard_len > GMIN) ? guard_len : GMIN;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= BRK_OFF;
         pos_q  <= '0;
         gcnt_q <= '0;
         glim_q <= GMIN;
         stop_q <= 1'b0;
      end else if (clr) begin
         st_q   <= BRK_OFF;
         pos_q  <= '0;
         gcnt_q <= '0;
         glim_q <= GMIN;
         stop_q <= 1'b0;
      end else begin
         unique case (st_q)
            BRK_OFF: begin
               if (start_cmd) st_q <= BRK_PEND;
            end
            BRK_PEND: begin
               if (tick && drained) begin
                  st_q   <= BRK_LOW;
                  pos_q  <= '0;
                  stop_q <= 1'b0;
               end
            end
            BRK_LOW: begin
               if (stop_cmd) stop_q <= 1'b1;
               if (tick) begin
                  if (pos_q == flen_last) begin
                     pos_q <= '0;
                     if (stop_q || stop_cmd) begin
                        st_q   <= BRK_GUARD;
                        gcnt_q <= '0;
                        glim_q <= glim_new;
                        stop_q <= 1'b0;
                     end
                  end else begin
                     pos_q <= pos_q + CNT_W'(1);
                  end
               end
            end
            BRK_GUARD: begin
               if (tick) begin
                  if (gcnt_q == glim_q - GUARD_W'(1)) st_q <= BRK_OFF;
                  else gcnt_q <= gcnt_q + GUARD_W'(1);
               end
            end
            default: st_q <= BRK_OFF;
         endcase
      end
   end

   assign st  = st_q;
   assign ovr = (st_q == BRK_LOW) || (st_q == BRK_GUARD);
   assign lvl = (st_q == BRK_GUARD);

   AST_PEND_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == BRK_PEND && $past(st_q) != BRK_PEND) |-> ($past(st_q) == BRK_OFF && $past(start_cmd)))
      else $error("break request taken while busy"); // R5
   AST_FRAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == BRK_GUARD && $past(st_q) == BRK_LOW) |-> ($past(pos_q) == $past(flen_last)))
      else $error("break ended inside a frame"); // R6
   AST_GUARD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == BRK_GUARD) |-> (glim_q >= GMIN)) else $error("guard shorter than floor"); // R7

endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx
   import uart_brk_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_BIT_EN = 1,
   parameter int GUARD_W     = 8,
   parameter int MIN_GUARD   = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               baud_tick,
   input  logic               wr_valid,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               cmd_tx_on,
   input  logic               cmd_tx_off,
   input  logic               cmd_tx_rst,
   input  logic               cmd_brk_start,
   input  logic               cmd_brk_stop,
   input  logic               cmd_addr_next,
   input  logic               multidrop_en,
   input  logic [GUARD_W-1:0] guard_len,
   output logic               tx_line,
   output logic               tx_ready,
   output logic               tx_empty
);

   localparam int FRAME_W = frame_bits(DATA_W, ADDR_BIT_EN);
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   generate
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_data
         $error("DATA_W must lie in 5..9");
      end
      if (GUARD_W < 4 || GUARD_W > 16) begin : g_bad_guard
         $error("GUARD_W must lie in 4..16");
      end
      if (MIN_GUARD < 1 || MIN_GUARD >= (1 << GUARD_W)) begin : g_bad_min
         $error("MIN_GUARD must be at least 1 and fit in GUARD_W bits");
      end
   endgenerate

   logic              on_q;
   logic              hold_full;
   logic [DATA_W-1:0] hold_data;
   logic              hold_addr;
   logic              wr_acc;
   logic              load_ok;
   logic              sh_line;
   logic              sh_busy;
   logic              sh_slot;
   logic              sh_take;
   logic [CNT_W-1:0]  flen_last;
   brk_st_t           brk_st;
   logic              brk_ovr;
   logic              brk_lvl;
   logic              brk_idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        on_q <= 1'b0;
      else if (cmd_tx_rst || cmd_tx_off) on_q <= 1'b0;
      else if (cmd_tx_on)                on_q <= 1'b1;
   end

   generate
      if (ADDR_BIT_EN != 0) begin : g_len_md
         assign flen_last = multidrop_en ? CNT_W'(FRAME_W - 1) : CNT_W'(FRAME_W - 2);
      end else begin : g_len_plain
         assign flen_last = CNT_W'(FRAME_W - 1);
      end
   endgenerate

   assign brk_idle = (brk_st == BRK_OFF);
   assign tx_ready = on_q && !hold_full && brk_idle;
   assign wr_acc   = wr_valid && tx_ready && !cmd_tx_rst;
   assign load_ok  = hold_full && on_q && (brk_idle || brk_st == BRK_PEND);
   assign tx_empty = !hold_full && !sh_busy && brk_idle;
   assign tx_line  = brk_ovr ? brk_lvl : sh_line;

   uart_brk_hold #(.DATA_W(DATA_W), .ADDR_BIT_EN(ADDR_BIT_EN)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (cmd_tx_rst),
      .wr_en     (wr_acc),
      .wr_data   (wr_data),
      .addr_cmd  (cmd_addr_next),
      .take      (sh_take),
      .full      (hold_full),
      .hold_data (hold_data),
      .hold_addr (hold_addr)
   );

   uart_brk_shift #(.DATA_W(DATA_W), .ADDR_BIT_EN(ADDR_BIT_EN),
                    .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (cmd_tx_rst),
      .tick      (baud_tick),
      .load_ok   (load_ok),
      .hold_data (hold_data),
      .hold_addr (hold_addr),
      .md        (multidrop_en),
      .line      (sh_line),
      .busy      (sh_busy),
      .slot      (sh_slot),
      .take      (sh_take)
   );

   uart_brk_seq #(.GUARD_W(GUARD_W), .MIN_GUARD(MIN_GUARD), .CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (cmd_tx_rst),
      .tick      (baud_tick),
      .start_cmd (cmd_brk_start),
      .stop_cmd  (cmd_brk_stop),
      .drained   (!hold_full && sh_slot),
      .flen_last (flen_last),
      .guard_len (guard_len),
      .st        (brk_st),
      .ovr       (brk_ovr),
      .lvl       (brk_lvl)
   );

   // guard-length watcher
   logic [GUARD_W:0] gwatch_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                gwatch_q <= '0;
      else if (brk_st != BRK_GUARD)              gwatch_q <= '0;
      else if (baud_tick && !(&gwatch_q))        gwatch_q <= gwatch_q + 1'b1;
   end

   AST_BRK_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_st == BRK_LOW && $past(brk_st) == BRK_PEND) |-> (!hold_full && !sh_busy))
      else $error("break began with data queued"); // R4
   AST_STATUS_BRK: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cmd_brk_start) && !$past(cmd_tx_rst) && $past(brk_st) != BRK_GUARD) |-> (!tx_ready && !tx_empty))
      else $error("status high after break request"); // R4
   AST_GUARD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_st == BRK_OFF && $past(brk_st) == BRK_GUARD && !$past(cmd_tx_rst)) |-> (gwatch_q >= MIN_GUARD))
      else $error("guard interval too short"); // R7
   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!sh_busy && brk_idle) |-> tx_line) else $error("idle line not high"); // R1
   AST_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmd_tx_off) |-> !tx_ready) else $error("off strobe lost"); // R10
   AST_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmd_tx_rst) |-> (tx_line && !tx_ready && tx_empty)) else $error("reset left activity"); // R11

endmodule

// File: tb/sim_uart_brk_tx.sv
module sim_uart_brk_tx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic [1:0] div = 2'd0;
   logic       wr_valid = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [5:0] cmd = 6'd0;   // 0 on, 1 off, 2 rst, 3 brk start, 4 brk stop, 5 addr
   logic       multidrop_en = 1'b0;
   logic [7:0] guard_len = 8'd0;
   logic       tx_line, tx_ready, tx_empty;

   int total = 0;
   int bad = 0;

   localparam logic [5:0] C_ON = 6'd1, C_OFF = 6'd2, C_RST = 6'd4,
                          C_BGO = 6'd8, C_BEND = 6'd16, C_ADR = 6'd32;

   // {addr strobe, multidrop, data, expected ninth bit}
   localparam logic [10:0] VEC [8] = '{
      {1'b0, 1'b0, 8'h55, 1'b0},
      {1'b0, 1'b0, 8'hA3, 1'b0},
      {1'b0, 1'b1, 8'h3C, 1'b0},
      {1'b1, 1'b1, 8'h81, 1'b1},
      {1'b0, 1'b1, 8'h81, 1'b0},
      {1'b1, 1'b0, 8'hF0, 1'b0},
      {1'b0, 1'b1, 8'h0F, 1'b0},
      {1'b1, 1'b1, 8'h00, 1'b1}
   };

   always #2 clk = ~clk;

   always @(negedge clk) begin
      div       <= div + 2'd1;
      baud_tick <= (div == 2'd3);
   end

   uart_brk_tx u0 (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
      .wr_valid(wr_valid), .wr_data(wr_data),
      .cmd_tx_on(cmd[0]), .cmd_tx_off(cmd[1]), .cmd_tx_rst(cmd[2]),
      .cmd_brk_start(cmd[3]), .cmd_brk_stop(cmd[4]), .cmd_addr_next(cmd[5]),
      .multidrop_en(multidrop_en), .guard_len(guard_len),
      .tx_line(tx_line), .tx_ready(tx_ready), .tx_empty(tx_empty)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic next_edge();
      do @(posedge clk); while (!baud_tick);
      @(negedge clk);
   endtask

   task automatic strobe(input logic [5:0] m);
      cmd = m;
      @(negedge clk);
      cmd = 6'd0;
   endtask

   task automatic put(input logic [7:0] d);
      wr_data  = d;
      wr_valid = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic grab(input int n, output logic [31:0] v);
      v = '0;
      for (int i = 0; i < n; i++) begin
         next_edge();
         v[i] = tx_line;
      end
   endtask

   function automatic logic [31:0] mkframe(input logic [7:0] d, input logic md, input logic a);
      return md ? {21'd0, 1'b1, a, d, 1'b0} : {22'd0, 1'b1, d, 1'b0};
   endfunction

   // counts low ticks of a break; issues a release after rel_at lows
   task automatic count_low(input int rel_at, input int restart_at, output int z);
      z = 0;
      while (tx_line == 1'b0 && z < 200) begin
         z++;
         if (z == rel_at) strobe(C_BEND);
         if (z == restart_at) strobe(C_BGO);
         next_edge();
      end
   endtask

   task automatic count_guard(input int restart_at, output int g, output bit low_seen);
      g = 0;
      low_seen = 0;
      while (!tx_ready && g < 300) begin
         if (!tx_line) low_seen = 1;
         g++;
         if (g == restart_at) strobe(C_BGO);
         next_edge();
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] v, e;
      int z, g;
      bit lo;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state: line high, disabled, empty
      chk(tx_line == 1'b1, "R1 reset line", tx_line, 1);
      chk(tx_ready == 1'b0, "R2 reset ready", tx_ready, 0);
      chk(tx_empty == 1'b1, "R3 reset empty", tx_empty, 1);

      // R10: on with off in the same cycle stays off
      strobe(C_ON | C_OFF);
      chk(tx_ready == 1'b0, "R10 off wins", tx_ready, 0);
      strobe(C_ON);
      chk(tx_ready == 1'b1, "R10 on", tx_ready, 1);

      // vector table: frame format and address flag
      for (int k = 0; k < 8; k++) begin
         logic [7:0] d;
         logic a_cmd, md, nine;
         int nb;
         {a_cmd, md, d, nine} = VEC[k];
         multidrop_en = md;
         if (a_cmd) strobe(C_ADR);
         put(d);
         chk(tx_empty == 1'b0, "R3 busy after write", tx_empty, 0);
         nb = md ? 11 : 10;
         grab(nb, v);
         e = mkframe(d, md, nine);
         chk(v == e, md ? "R9 R1 frame" : "R1 frame", v, e);
         chk(tx_empty == 1'b0, "R3 during stop bit", tx_empty, 0);
         next_edge();
         chk(tx_empty == 1'b1 && tx_line == 1'b1, "R3 empty after stop", tx_empty, 1);
      end

      // R1: back-to-back frames without gap
      multidrop_en = 1'b0;
      put(8'hC5);
      next_edge();
      chk(tx_ready == 1'b1 && tx_line == 1'b0, "R1 first start", tx_line, 0);
      put(8'h6A);
      grab(19, v);
      e = ({mkframe(8'h6A, 1'b0, 1'b0)[9:0], mkframe(8'hC5, 1'b0, 1'b0)[9:0]}) >> 1;
      chk(v == e, "R1 back-to-back", v, e);
      next_edge();
      chk(tx_empty == 1'b1, "R3 empty after pair", tx_empty, 1);

      // R2: write while holding stage full is dropped
      put(8'h12);
      put(8'hEE);
      grab(10, v);
      e = mkframe(8'h12, 1'b0, 1'b0);
      chk(v == e, "R2 first kept", v, e);
      grab(12, v);
      chk(v[11:0] == 12'hFFF, "R2 second dropped", v, 32'hFFF);

      // R2: write while off is dropped
      strobe(C_OFF);
      put(8'h00);
      chk(tx_empty == 1'b1, "R2 off write empty", tx_empty, 1);
      strobe(C_ON);
      grab(15, v);
      chk(v[14:0] == 15'h7FFF, "R2 off write unsent", v, 32'h7FFF);

      // break 1: queued char drains first, 10-bit frames, guard floor 12
      guard_len = 8'd5;
      put(8'h96);
      strobe(C_BGO);
      grab(10, v);
      e = mkframe(8'h96, 1'b0, 1'b0);
      chk(v == e, "R4 drain before break", v, e);
      next_edge();
      chk(tx_line == 1'b0, "R4 break follows", tx_line, 0);
      count_low(3, 5, z);
      chk(z == 10, "R6 R5 break length 10", z, 10);
      count_guard(4, g, lo);
      chk(g == 12, "R7 guard floor", g, 12);
      chk(lo == 1'b0, "R5 guard stays high", lo, 0);
      grab(14, v);
      chk(v[13:0] == 14'h3FFF && tx_empty, "R5 no second break", v, 32'h3FFF);

      // break 2: early release ignored, 11-bit frames, guard 20
      multidrop_en = 1'b1;
      guard_len = 8'd20;
      strobe(C_BEND);
      strobe(C_BGO);
      chk(tx_ready == 1'b0 && tx_empty == 1'b0, "R4 status cleared", {tx_ready, tx_empty}, 0);
      strobe(C_BEND);
      next_edge();
      chk(tx_line == 1'b0, "R8 break running", tx_line, 0);
      count_low(25, 0, z);
      chk(z == 33, "R8 R6 break length 33", z, 33);
      count_guard(0, g, lo);
      chk(g == 20, "R7 guard programmed", g, 20);
      chk(lo == 1'b0, "R7 guard high", lo, 0);

      // R11: reset mid-frame
      multidrop_en = 1'b0;
      put(8'h00);
      grab(4, v);
      chk(v[3:0] == 4'h0, "R1 zeros sent", v, 0);
      strobe(C_RST);
      chk(tx_line == 1'b1 && tx_ready == 1'b0 && tx_empty == 1'b1, "R11 reset frame",
          {tx_line, tx_ready, tx_empty}, 3'b101);
      grab(12, v);
      chk(v[11:0] == 12'hFFF, "R11 frame aborted", v, 32'hFFF);

      // R11: reset during break
      strobe(C_ON);
      strobe(C_BGO);
      grab(3, v);
      chk(v[2:0] == 3'b000, "R6 break low", v, 0);
      strobe(C_RST);
      chk(tx_line == 1'b1 && tx_empty == 1'b1, "R11 reset break", {tx_line, tx_empty}, 2'b11);
      strobe(C_ON);
      chk(tx_ready == 1'b1, "R11 usable again", tx_ready, 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule